// File: doc/BRIEF.md
# Code Phase-Accumulator Oscillator

This block is the rate generator that paces a spreading-code generator. A 26-bit phase accumulator gains a programmable 25-bit step on every sample clock. Each time the accumulator wraps past its top bit, the block raises a one-cycle enable, `half_chip_en`, and the code generator advances by half a chip on it. The step must therefore be set to twice the wanted chip rate. Software writes the step over a 16-bit register port in two words. The upper word is held in a holding buffer. The lower word then commits the full step in one go, so the oscillator never runs on a step that mixes an old half with a new one.

A periodic measurement strobe (`tic`) freezes the ten most significant accumulator bits into a readback register. While `preset_mode` is high, the same strobe also overwrites the whole accumulator with a coarse 8-bit start phase. That phase lands in the top bits and the lower bits are cleared. This lets software place the code phase at a known point.

Top module: `code_nco`

## Requirements
- R1: After reset the active step, the holding buffer, the preset register and the accumulator are zero. `half_chip_en` is 0 and `phase_rd` reads 0.
- R2: A write with `wr_sel` = 2'b00 stores `wr_data[8:0]` in the holding buffer as step bits 24..16. `wr_data[15:9]` of that write are ignored.
- R3: A write with `wr_sel` = 2'b00 on its own leaves the active step unchanged.
- R4: A write with `wr_sel` = 2'b01 sets the active step to {holding buffer, `wr_data[15:0]`}, and the accumulator uses it from the next cycle. If no upper write came first, the buffer's current contents supply bits 24..16.
- R5: A write with `wr_sel` = 2'b11 changes no register.
- R6: Outside a preset load, the accumulator gains the active step modulo 2^26 on every clock edge. `half_chip_en` is high for exactly the one cycle that follows an edge at which that addition carries out of bit 25. With a step of 2^24 this happens on every fourth edge.
- R7: On a clock edge with `tic` high, accumulator bits 25..16, as they stood before that edge, are copied to `phase_rd[9:0]`. `phase_rd[15:10]` read 0. The value holds until the next strobe.
- R8: A write with `wr_sel` = 2'b10 stores `wr_data[7:0]` in the preset register. An edge with `tic` and `preset_mode` both high replaces the accumulator with {preset, 18 zero bits}.
- R9: A strobe with `preset_mode` low leaves the accumulator advancing normally, whatever the preset register holds.
- R10: The edge that performs a preset load produces no `half_chip_en` pulse, even if the addition would have carried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 00 step upper, 01 step lower/commit, 10 preset phase, 11 none |
| wr_data | input | 16 | Write data word |
| preset_mode | input | 1 | 1 = preset mode, 0 = update mode |
| tic | input | 1 | Measurement strobe, one cycle |
| half_chip_en | output | 1 | Half-chip enable pulse from accumulator wrap |
| phase_rd | output | 16 | Captured accumulator bits 25..16, zero-extended |

## Verification
Several step values are used. A step of 2^16 makes the captured phase equal the elapsed cycle count, which isolates how the upper and lower words combine: ignored upper bits, a lone upper write, and reuse of the buffer. A step of 2^24 exposes the wrap period and pulse width through `half_chip_en`. A zero step freezes the accumulator, so a preset load can be told apart from a strobe that only captures. A preset placed just below the wrap point shows whether a load edge that would have carried still emits a pulse.

// File: rtl/code_nco_pkg.sv
package code_nco_pkg;

    // Register write targets on the 16-bit write port
    typedef enum logic [1:0] {
        SEL_STEP_HI = 2'b00,
        SEL_STEP_LO = 2'b01,
        SEL_PRESET  = 2'b10,
        SEL_NONE    = 2'b11
    } wr_sel_e;

endpackage

// File: rtl/nco_ctrl_regs.sv
module nco_ctrl_regs
    import code_nco_pkg::*;
#(
    parameter int INC_W = 25,
    parameter int BUS_W = 16,
    parameter int PRE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [1:0]               wr_sel,
    input  logic [BUS_W-1:0]         wr_data,
    output logic [INC_W-BUS_W-1:0]   hold_o,
    output logic [INC_W-1:0]         step_o,
    output logic [PRE_W-1:0]         preset_o
);
    localparam int HI_W = INC_W - BUS_W;

    typedef struct packed {
        logic [HI_W-1:0]  hold;
        logic [INC_W-1:0] step;
        logic [PRE_W-1:0] preset;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (wr_sel_e'(wr_sel))
                SEL_STEP_HI: r_d.hold   = wr_data[HI_W-1:0];
                SEL_STEP_LO: r_d.step   = {r_q.hold, wr_data};
                SEL_PRESET:  r_d.preset = wr_data[PRE_W-1:0];
                default:     r_d        = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign hold_o   = r_q.hold;
    assign step_o   = r_q.step;
    assign preset_o = r_q.preset;
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int ACC_W = 26,
    parameter int INC_W = 25,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] step,
    input  logic [PRE_W-1:0] preset,
    input  logic             load,
    output logic [ACC_W-1:0] acc_o,
    output logic             wrap_o
);
    localparam int SUM_W = ACC_W + 1;
    localparam int PAD_W = SUM_W - INC_W;
    localparam int LOW_W = ACC_W - PRE_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             wrap;
    } acc_t;

    acc_t a_d, a_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = {1'b0, a_q.acc} + {{PAD_W{1'b0}}, step};
        a_d = a_q;
        if (load) begin
            a_d.acc  = {preset, {LOW_W{1'b0}}};
            a_d.wrap = 1'b0;
        end else begin
            a_d.acc  = sum[ACC_W-1:0];
            a_d.wrap = sum[ACC_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign acc_o  = a_q.acc;
    assign wrap_o = a_q.wrap;
endmodule

// File: rtl/nco_tic_capture.sv
module nco_tic_capture #(
    parameter int CAP_W = 10,
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tic,
    input  logic [CAP_W-1:0] acc_top,
    output logic [BUS_W-1:0] rd_o
);
    typedef struct packed {
        logic [CAP_W-1:0] cap;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (tic) c_d.cap = acc_top;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign rd_o = {{(BUS_W-CAP_W){1'b0}}, c_q.cap};
endmodule

// File: rtl/code_nco.sv
module code_nco #(
    parameter int ACC_W = 26,
    parameter int INC_W = 25,
    parameter int BUS_W = 16,
    parameter int CAP_W = 10,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             preset_mode,
    input  logic             tic,
    output logic             half_chip_en,
    output logic [BUS_W-1:0] phase_rd
);
    localparam int HI_W = INC_W - BUS_W;

    logic [HI_W-1:0]  hold_w;
    logic [INC_W-1:0] step_w;
    logic [PRE_W-1:0] preset_w;
    logic [ACC_W-1:0] acc_w;
    logic             load_w;

    assign load_w = tic & preset_mode;

    nco_ctrl_regs #(.INC_W(INC_W), .BUS_W(BUS_W), .PRE_W(PRE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .hold_o   (hold_w),
        .step_o   (step_w),
        .preset_o (preset_w)
    );

    nco_phase_acc #(.ACC_W(ACC_W), .INC_W(INC_W), .PRE_W(PRE_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step_w),
        .preset (preset_w),
        .load   (load_w),
        .acc_o  (acc_w),
        .wrap_o (half_chip_en)
    );

    nco_tic_capture #(.CAP_W(CAP_W), .BUS_W(BUS_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .tic     (tic),
        .acc_top (acc_w[ACC_W-1 -: CAP_W]),
        .rd_o    (phase_rd)
    );
endmodule

// File: rtl/code_nco_chk.sv
module code_nco_chk #(
    parameter int ACC_W = 26,
    parameter int INC_W = 25,
    parameter int BUS_W = 16,
    parameter int PRE_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [1:0]             wr_sel,
    input logic [BUS_W-1:0]       wr_data,
    input logic                   preset_mode,
    input logic                   tic,
    input logic                   half_chip_en,
    input logic [BUS_W-1:0]       phase_rd,
    input logic [ACC_W-1:0]       acc,
    input logic [INC_W-1:0]       step,
    input logic [INC_W-BUS_W-1:0] hold,
    input logic [PRE_W-1:0]       preset
);
    localparam int LOW_W = ACC_W - PRE_W;

    AST_UPPER_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == 2'b01) |=> $stable(step)); // R3

    AST_LOWER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b01) |=> step == {$past(hold), $past(wr_data)}); // R4

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        half_chip_en |=> !half_chip_en); // R6

    AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(tic && preset_mode) |=> acc == $past(acc) + ACC_W'($past(step))); // R9

    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tic |=> $stable(phase_rd)); // R7

    AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tic && preset_mode) |=> acc == {$past(preset), {LOW_W{1'b0}}}); // R8

    AST_PRESET_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (tic && preset_mode) |=> !half_chip_en); // R10
endmodule

bind code_nco code_nco_chk #(
    .ACC_W(ACC_W), .INC_W(INC_W), .BUS_W(BUS_W), .PRE_W(PRE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .preset_mode  (preset_mode),
    .tic          (tic),
    .half_chip_en (half_chip_en),
    .phase_rd     (phase_rd),
    .acc          (acc_w),
    .step         (step_w),
    .hold         (hold_w),
    .preset       (preset_w)
);

// File: tb/code_nco_test.sv
module code_nco_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'b11;
    logic [15:0] wr_data = '0;
    logic        preset_mode = 1'b0;
    logic        tic = 1'b0;
    logic        half_chip_en;
    logic [15:0] phase_rd;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    code_nco uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .preset_mode  (preset_mode),
        .tic          (tic),
        .half_chip_en (half_chip_en),
        .phase_rd     (phase_rd)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic wr(logic [1:0] sel, logic [15:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'b11;
    endtask

    task automatic strobe(logic mode);
        tic = 1'b1; preset_mode = mode;
        @(posedge clk); @(negedge clk);
        tic = 1'b0; preset_mode = 1'b0;
    endtask

    task automatic zero_phase();
        wr(2'b10, 16'h0000);
        strobe(1'b1);
    endtask

    task automatic t_reset();
        chk("R1 en", half_chip_en, 0);
        chk("R1 rd", phase_rd, 0);
        idle(3);
        strobe(1'b0);
        chk("R1 zero step", phase_rd, 0);
        chk("R1 no pulse", half_chip_en, 0);
    endtask

    task automatic t_split();
        wr(2'b00, 16'h0001);
        wr(2'b01, 16'h0000);
        zero_phase(); idle(5); strobe(1'b0);
        chk("R4 split step", phase_rd, 5);
    endtask

    task automatic t_upper_bits();
        wr(2'b00, 16'hFE02);
        wr(2'b01, 16'h0000);
        zero_phase(); idle(3); strobe(1'b0);
        chk("R2 ignored bits", phase_rd, 6);
    endtask

    task automatic t_upper_alone();
        wr(2'b00, 16'h0007);
        zero_phase(); idle(4); strobe(1'b0);
        chk("R3 upper alone", phase_rd, 8);
    endtask

    task automatic t_reuse_hold();
        wr(2'b01, 16'h8000);
        zero_phase(); idle(2); strobe(1'b0);
        chk("R4 reuse hold", phase_rd, 15);
    endtask

    task automatic t_sel_none();
        wr(2'b11, 16'h1234);
        zero_phase(); idle(2); strobe(1'b0);
        chk("R5 no target", phase_rd, 15);
    endtask

    task automatic t_rate();
        int cnt = 0, first = 0, twice = 0;
        logic prev = 1'b0;
        wr(2'b00, 16'h0100);
        wr(2'b01, 16'h0000);
        zero_phase();
        for (int i = 1; i <= 40; i++) begin
            idle(1);
            if (half_chip_en) begin
                cnt++;
                if (first == 0) first = i;
                if (prev) twice++;
            end
            prev = half_chip_en;
        end
        chk("R6 pulse count", cnt, 10);
        chk("R6 first pulse", first, 4);
        chk("R6 one cycle", twice, 0);
    endtask

    task automatic t_capture();
        zero_phase(); idle(2); strobe(1'b0);
        chk("R7 capture", phase_rd, 512);
        idle(3);
        chk("R7 hold", phase_rd, 512);
    endtask

    task automatic t_preset_load();
        wr(2'b00, 16'h0000);
        wr(2'b01, 16'h0000);
        wr(2'b10, 16'h00AB);
        strobe(1'b1);
        strobe(1'b0);
        chk("R8 preset load", phase_rd, 16'h02AC);
    endtask

    task automatic t_preset_update();
        wr(2'b10, 16'h0011);
        strobe(1'b0);
        chk("R9 no load", phase_rd, 16'h02AC);
        strobe(1'b0);
        chk("R9 still", phase_rd, 16'h02AC);
        strobe(1'b1);
        strobe(1'b0);
        chk("R8 new preset", phase_rd, 16'h0044);
    endtask

    task automatic t_suppress();
        wr(2'b00, 16'h0100);
        wr(2'b01, 16'h0000);
        wr(2'b10, 16'h00FF);
        strobe(1'b1);
        chk("R10 load edge", half_chip_en, 0);
        strobe(1'b1);
        chk("R10 would carry", half_chip_en, 0);
        idle(1);
        chk("R6 carry after", half_chip_en, 1);
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_split();
        t_upper_bits();
        t_upper_alone();
        t_reuse_hold();
        t_sel_none();
        t_rate();
        t_capture();
        t_preset_load();
        t_preset_update();
        t_suppress();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule